// File: doc/BRIEF.md
# Integer Add, Extend and Compare Stage with Dual-Width Flags

This block is one arithmetic step of an integer execution pipeline. Each cycle it takes two 64-bit operands, a two-bit carry input, a sticky-overflow input, an operation code and a byte length. One clock edge later it presents a 64-bit result with its flags. The stage supports three operations:

- **Add with carry.** The result comes with a carry-out and a signed overflow for the full 64-bit word. It also gives a carry-out and an overflow for the low 32-bit half, from the same pass.
- **Sign extension.** The low 1, 2 or 4 bytes of the first operand are sign-extended to 64 bits.
- **Compare support.** This is a carry-less sum. An earlier stage has already inverted one operand, so this sum is the subtraction a compare needs.

All outputs are registered. The flags of the current add feed a sticky overflow bit.

Top module: `alu_carry_stage`

## Requirements
- R1: When `op_i` is 0 (add), the 65-bit value {`carry_o[0]`, `result_o`} one cycle later equals `a_i + b_i + carry_i[0]`. Bit 0 of the carry ports is the full-width carry.
- R2: For an add, `carry_o[1]` is bit 32 of (`a_i[31:0] + b_i[31:0] + carry_i[0]`). Bit 1 of `carry_i` has no effect on any output.
- R3: For an add, `ov_o[0]` equals (`carry_o[0]` XOR `result_o[63]`) AND NOT (`a_i[63]` XOR `b_i[63]`). Bit 0 of the overflow port is the full-width overflow.
- R4: For an add, `ov_o[1]` equals (`carry_o[1]` XOR `result_o[31]`) AND NOT (`a_i[31]` XOR `b_i[31]`). Bit 1 of the overflow port is the 32-bit overflow.
- R5: When `op_i` is 1 (sign extend) and `len_i` is n with n in {1, 2, 4}, the result has two parts. The low 8·n bits of `result_o` copy `a_i`. Every bit above them repeats `a_i[8·n−1]`.
- R6: When `op_i` is 1 and `len_i` is not 1, 2 or 4, `result_o` equals `a_i`.
- R7: When `op_i` is 2 (compare), `result_o` is the low 64 bits of `a_i + b_i`, whatever `carry_i` holds.
- R8: For every `op_i` other than 0, both `carry_o` bits and both `ov_o` bits are 0.
- R9: For an add, `so_o` is `so_i` OR the full-width overflow. For every other operation, `so_o` equals `so_i`.
- R10: When `op_i` is 3, `result_o` is 0.
- R11: All outputs are registered, one cycle after the inputs. While `rst` is high at a rising edge, all outputs become 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation: 0 add, 1 sign extend, 2 compare, 3 none |
| len_i | input | 4 | Sign-extension source length in bytes |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| carry_i | input | 2 | Carry in: bit 0 full width, bit 1 32-bit |
| so_i | input | 1 | Sticky overflow in |
| result_o | output | 64 | Registered result |
| carry_o | output | 2 | Carry out: bit 0 full width, bit 1 32-bit |
| ov_o | output | 2 | Overflow: bit 0 full width, bit 1 32-bit |
| so_o | output | 1 | Sticky overflow out |

## Verification
The clocked properties take three things for granted:

- `op_i`, `a_i`, `b_i`, `carry_i` and `so_i` are known values at every rising edge after reset.
- An operation code of 3 is a legal input that must produce a zero result.
- No input changes between the edge that samples it and the edge that registers the outcome.

The stimulus changes inputs only on falling edges and holds them for a full cycle. It sweeps every operation code over a set of operands chosen to sit on the 32-bit and 64-bit sign and carry boundaries. It also sweeps both carry-in bits and the sticky bit, so each flag formula is exercised with the two carry inputs set both equal and different.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SEXT = 2'd1,
    OP_CMP  = 2'd2,
    OP_NONE = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic ca_half;
    logic ca_full;
  } carry_pair_t;
endpackage

// File: rtl/alu_adder.sv
// Full-width adder that also yields the carry out of the low half
// and the signed overflow of both widths from one carry chain.
module alu_adder #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co_full,
  output logic         co_half,
  output logic         ov_full,
  output logic         ov_half
);
  logic [W:0] total;

  assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum     = total[W-1:0];
  assign co_full = total[W];
  // Carry into bit HW recovered from the sum bit and the operand bits there.
  assign co_half = total[HW] ^ a[HW] ^ b[HW];

  assign ov_full = (co_full ^ sum[W-1])  & ~(a[W-1]  ^ b[W-1]);
  assign ov_half = (co_half ^ sum[HW-1]) & ~(a[HW-1] ^ b[HW-1]);
endmodule

// File: rtl/alu_sext.sv
// Sign extension from a byte length chosen among powers of two.
module alu_sext #(
  parameter int W     = 64,
  parameter int LEN_W = 4,
  parameter int NSEL  = 3
) (
  input  logic [W-1:0]     a,
  input  logic [LEN_W-1:0] len,
  output logic [W-1:0]     res
);
  logic [W-1:0] ext [NSEL];

  for (genvar k = 0; k < NSEL; k++) begin : g_len
    localparam int NB = 8 * (1 << k);
    assign ext[k] = {{(W - NB){a[NB-1]}}, a[NB-1:0]};
  end

  always_comb begin
    res = a;
    for (int k = 0; k < NSEL; k++) begin
      if (int'(len) == (1 << k)) res = ext[k];
    end
  end
endmodule

// File: rtl/alu_carry_stage.sv
module alu_carry_stage
  import alu_pkg::*;
#(
  parameter int W     = 64,
  parameter int HW    = 32,
  parameter int LEN_W = 4,
  parameter int NSEL  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [1:0]       carry_i,
  input  logic             so_i,
  output logic [W-1:0]     result_o,
  output logic [1:0]       carry_o,
  output logic [1:0]       ov_o,
  output logic             so_o
);
  localparam int TOTW = W + 1;

  alu_op_e      op;
  logic         is_add;
  logic         add_cin;
  logic [W-1:0] sum;
  logic         co_full, co_half, ov_full, ov_half;
  logic [W-1:0] ext_res;
  logic [W-1:0] res_d;
  carry_pair_t  ca_d;
  logic [1:0]   ov_d;
  logic         so_d;

  assign op      = alu_op_e'(op_i);
  assign is_add  = (op == OP_ADD);
  // Compare shares the adder with its carry forced to zero.
  assign add_cin = is_add & carry_i[0];

  alu_adder #(.W(W), .HW(HW)) u_adder (
    .a       (a_i),
    .b       (b_i),
    .cin     (add_cin),
    .sum     (sum),
    .co_full (co_full),
    .co_half (co_half),
    .ov_full (ov_full),
    .ov_half (ov_half)
  );

  alu_sext #(.W(W), .LEN_W(LEN_W), .NSEL(NSEL)) u_sext (
    .a   (a_i),
    .len (len_i),
    .res (ext_res)
  );

  always_comb begin
    res_d = '0;
    ca_d  = '0;
    ov_d  = '0;
    so_d  = so_i;
    unique case (op)
      OP_ADD: begin
        res_d        = sum;
        ca_d.ca_full = co_full;
        ca_d.ca_half = co_half;
        ov_d         = {ov_half, ov_full};
        so_d         = so_i | ov_full;
      end
      OP_SEXT: res_d = ext_res;
      OP_CMP:  res_d = sum;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= '0;
      ov_o     <= '0;
      so_o     <= 1'b0;
    end else begin
      result_o <= res_d;
      carry_o  <= {ca_d.ca_half, ca_d.ca_full};
      ov_o     <= ov_d;
      so_o     <= so_d;
    end
  end

  assert_add_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'd0) |=> ({carry_o[0], result_o} ==
      ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + TOTW'($past(carry_i[0])))));

  assert_ov_full_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'd0) |=> (ov_o[0] ==
      ((carry_o[0] ^ result_o[W-1]) & ~($past(a_i[W-1]) ^ $past(b_i[W-1])))));

  assert_ov_half_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'd0) |=> (ov_o[1] ==
      ((carry_o[1] ^ result_o[HW-1]) & ~($past(a_i[HW-1]) ^ $past(b_i[HW-1])))));

  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i != 2'd0) |=> (carry_o == 2'b00 && ov_o == 2'b00));

  assert_so_keep_R9: assert property (@(posedge clk) disable iff (rst)
    so_i |=> so_o);

  assert_so_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (op_i != 2'd0) |=> (so_o == $past(so_i)));

  assert_none_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'd3) |=> (result_o == '0));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (result_o == '0 && carry_o == 2'b00 && ov_o == 2'b00 && !so_o));
endmodule

// File: tb/alu_carry_stage_tb.sv
module alu_carry_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    op_i = 2'd0;
  logic [3:0]    len_i = 4'd0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic [1:0]    carry_i = 2'b00;
  logic          so_i = 1'b0;
  logic [W-1:0]  result_o;
  logic [1:0]    carry_o;
  logic [1:0]    ov_o;
  logic          so_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [W-1:0] vals [10];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_carry_stage u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .len_i(len_i), .a_i(a_i), .b_i(b_i),
    .carry_i(carry_i), .so_i(so_i), .result_o(result_o), .carry_o(carry_o),
    .ov_o(ov_o), .so_o(so_o)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [3:0] len,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] cin, input logic so);
    @(negedge clk);
    op_i = op; len_i = len; a_i = a; b_i = b; carry_i = cin; so_i = so;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] sext_exp(input logic [W-1:0] a, input int len);
    logic [W-1:0] r;
    int n;
    if (len != 1 && len != 2 && len != 4) return a;
    n = 8 * len;
    for (int i = 0; i < W; i++) r[i] = (i < n) ? a[i] : a[n-1];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    vals[0] = 64'h0;
    vals[1] = 64'h1;
    vals[2] = 64'h0000_0000_7FFF_FFFF;
    vals[3] = 64'h0000_0000_8000_0000;
    vals[4] = 64'h0000_0000_FFFF_FFFF;
    vals[5] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[6] = 64'h8000_0000_0000_0000;
    vals[7] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[8] = 64'hFFFF_FFFF_8000_0080;
    vals[9] = 64'h1234_5678_9ABC_80FF;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(result_o == '0, "R11 reset result", result_o, '0);
    check({carry_o, ov_o, so_o} == 5'b0, "R11 reset flags", W'({carry_o, ov_o, so_o}), '0);
    @(negedge clk);
    rst = 1'b0;

    // R1..R4, R9: add sweep, incl. R2 carry_i[1] toggled
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        for (int c = 0; c < 4; c++) begin
          for (int s = 0; s < 2; s++) begin
            logic [W:0]  full;
            logic [32:0] half;
            logic ov64, ov32;
            apply(2'd0, 4'd0, vals[i], vals[j], 2'(c), 1'(s));
            full = {1'b0, vals[i]} + {1'b0, vals[j]} + (W+1)'(c & 1);
            half = {1'b0, vals[i][31:0]} + {1'b0, vals[j][31:0]} + 33'(c & 1);
            ov64 = (full[W] ^ full[W-1]) & ~(vals[i][W-1] ^ vals[j][W-1]);
            ov32 = (half[32] ^ full[31]) & ~(vals[i][31] ^ vals[j][31]);
            check(result_o == full[W-1:0], "R1 sum", result_o, full[W-1:0]);
            check(carry_o[0] == full[W], "R1 carry", W'(carry_o[0]), W'(full[W]));
            check(carry_o[1] == half[32], "R2 carry32", W'(carry_o[1]), W'(half[32]));
            check(ov_o[0] == ov64, "R3 ov", W'(ov_o[0]), W'(ov64));
            check(ov_o[1] == ov32, "R4 ov32", W'(ov_o[1]), W'(ov32));
            check(so_o == (1'(s) | ov64), "R9 sticky add", W'(so_o), W'(1'(s) | ov64));
          end
        end
      end
    end

    // R5, R6, R8, R9: sign extension across lengths 0..8
    for (int i = 0; i < 10; i++) begin
      for (int l = 0; l < 9; l++) begin
        logic [W-1:0] e;
        apply(2'd1, 4'(l), vals[i], vals[9 - i], 2'b11, 1'(l & 1));
        e = sext_exp(vals[i], l);
        if (l == 1 || l == 2 || l == 4)
          check(result_o == e, "R5 sext", result_o, e);
        else
          check(result_o == e, "R6 sext passthrough", result_o, e);
        check({carry_o, ov_o} == 4'b0, "R8 sext flags", W'({carry_o, ov_o}), '0);
        check(so_o == 1'(l & 1), "R9 sticky pass", W'(so_o), W'(l & 1));
      end
    end

    // R7, R8, R9: compare ignores carry_i
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        for (int c = 0; c < 4; c++) begin
          logic [W-1:0] e;
          apply(2'd2, 4'd0, vals[i], vals[j], 2'(c), 1'(c >> 1));
          e = vals[i] + vals[j];
          check(result_o == e, "R7 compare", result_o, e);
          check({carry_o, ov_o} == 4'b0, "R8 compare flags", W'({carry_o, ov_o}), '0);
          check(so_o == 1'(c >> 1), "R9 sticky cmp", W'(so_o), W'(c >> 1));
        end
      end
    end

    // R10, R8: unused opcode
    for (int i = 0; i < 10; i++) begin
      apply(2'd3, 4'd1, vals[i], vals[7], 2'b11, 1'b0);
      check(result_o == '0, "R10 none result", result_o, '0);
      check({carry_o, ov_o, so_o} == 5'b0, "R8 none flags", W'({carry_o, ov_o, so_o}), '0);
    end

    // R11: reset mid-run clears a nonzero outcome
    apply(2'd0, 4'd0, vals[5], vals[1], 2'b01, 1'b1);
    check(result_o != '0 && so_o, "R11 pre-reset nonzero", result_o, 64'h8000_0000_0000_0001);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(result_o == '0, "R11 reset result mid", result_o, '0);
    check({carry_o, ov_o, so_o} == 5'b0, "R11 reset flags mid", W'({carry_o, ov_o, so_o}), '0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule